// File: doc/BRIEF.md
# Boot-Strap Latch and Code-Region Remap Decoder

This block decides which memory answers at the bottom of the CPU's code space. After reset is released it counts rising clock edges and samples a dedicated boot pin and a second boot pin that shares a GPIO. The pair sets the reset value of a two-bit remap mode. A CPU-start enable and a GPIO-release flag rise once that sample is taken. A standby-exit pulse reopens the sampling window, so the pins are read again with the same edge count, and CPU start is held off until then.

While the CPU runs, software may overwrite the mode through a small write port. Each address presented with a valid strobe is decoded, one cycle later, into a one-hot target select and an offset from the base of the selected region. The targets are main flash, system memory, SRAM1, SRAM2, the two NOR/PSRAM regions of an external memory controller, and that controller's register space. The low 64 MB alias window follows the mode. Every fixed region keeps decoding at its own address in all modes. External-memory mode also opens a second 64 MB window and refuses register access to the controller. Reserved and unmapped addresses raise a bus error.

Top module: `boot_remap_decoder`

## Requirements
- R1: On the 4th rising clock edge after reset is released, both boot pins are sampled. `cpu_run` and `pin_release` are low before that edge and high from that edge on.
- R2: A `standby_exit` high at a rising edge drops `cpu_run` and `pin_release` at that edge. The pins are sampled again on the 4th rising edge that follows, where both flags return high.
- R3: The sampled pins set the remap mode as mode = {boot_b & boot_a, boot_a}. The codes are 00 flash, 01 system memory, 11 SRAM1 and 10 external memory. So `boot_a`=0 gives flash, `boot_a`=1 with `boot_b`=0 gives system memory, and both high give SRAM1. Reset puts the mode at 00.
- R4: A `remap_we` pulse at a rising edge while `cpu_run` is high loads `remap_wdata` into the mode. While `cpu_run` is low the write is ignored.
- R5: Addresses 0x0000_0000–0x03FF_FFFF select the target given by the mode, and the offset equals the address. Mode 10 selects NOR/PSRAM region 1.
- R6: An alias address at or beyond the target's size raises a bus error. The sizes are flash 0x10_0000, system memory 0x7800 and SRAM1 0x1_C000.
- R7: Addresses 0x0400_0000–0x07FF_FFFF select NOR/PSRAM region 2 with offset address−0x0400_0000 in mode 10, and raise a bus error in every other mode.
- R8: In every mode the fixed regions decode with offset equal to the address minus the base. These are flash 0x0800_0000–0x080F_FFFF, system memory 0x1FFF_0000–0x1FFF_77FF, SRAM1 0x2000_0000–0x2001_BFFF and SRAM2 0x2001_C000–0x2001_FFFF.
- R9: Controller registers at 0xA000_0000–0xA000_0FFF select the register target, except in mode 10, where they raise a bus error.
- R10: Select bit order is 0 flash, 1 system memory, 2 SRAM1, 3 SRAM2, 4 NOR/PSRAM 1, 5 NOR/PSRAM 2, 6 controller registers. Outputs follow `addr_valid` by one clock. At most one select bit or `bus_err` is high, and all are zero, with zero offset, for a cycle without `addr_valid`.
- R11: Any other address, including 0x0810_0000–0x0FFF_FFFF, raises `bus_err` for one cycle, with no select and zero offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby_exit | input | 1 | Pulse: device leaves standby, resample boot pins |
| boot_a | input | 1 | Dedicated boot pin |
| boot_b | input | 1 | Boot pin shared with a GPIO |
| remap_we | input | 1 | Software write strobe for the remap mode |
| remap_wdata | input | 2 | New remap mode |
| addr_valid | input | 1 | Address strobe |
| addr | input | 32 | CPU address |
| tgt_sel | output | 7 | One-hot target select |
| tgt_offset | output | 32 | Offset inside the selected region |
| bus_err | output | 1 | Reserved or refused access |
| pin_release | output | 1 | Shared boot pin sampled, GPIO free |
| cpu_run | output | 1 | CPU start enable |

## Verification
A miscounted edge counter moves the rise of `cpu_run` off the 4th edge, and the per-clock comparison catches it on that cycle. A wrong mode stays hidden until the next access to the alias window, the second 64 MB window or the controller registers. There it appears as a wrong select bit or a false bus error one clock after the strobe. The address list is therefore replayed in every mode and after each resample. A bad base or size shows on the next access near a region's edge as a wrong offset or a wrong error.

// File: rtl/boot_remap_decoder.sv
module boot_remap_decoder #(
  parameter int          CAPTURE_EDGE = 4,
  parameter logic [31:0] FLASH_BYTES  = 32'h0010_0000,
  parameter logic [31:0] SYS_BYTES    = 32'h0000_7800,
  parameter logic [31:0] SRAM1_BYTES  = 32'h0001_C000,
  parameter logic [31:0] SRAM2_BYTES  = 32'h0000_4000,
  parameter logic [31:0] CTL_BASE     = 32'hA000_0000,
  parameter logic [31:0] CTL_BYTES    = 32'h0000_1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        standby_exit,
  input  logic        boot_a,
  input  logic        boot_b,
  input  logic        remap_we,
  input  logic [1:0]  remap_wdata,
  input  logic        addr_valid,
  input  logic [31:0] addr,
  output logic [6:0]  tgt_sel,
  output logic [31:0] tgt_offset,
  output logic        bus_err,
  output logic        pin_release,
  output logic        cpu_run
);
  localparam int          CW         = $clog2(CAPTURE_EDGE + 1);
  localparam logic [31:0] ALIAS_SPAN = 32'h0400_0000;
  localparam logic [31:0] FLASH_BASE = 32'h0800_0000;
  localparam logic [31:0] SYS_BASE   = 32'h1FFF_0000;
  localparam logic [31:0] SRAM1_BASE = 32'h2000_0000;
  localparam logic [31:0] SRAM2_BASE = SRAM1_BASE + SRAM1_BYTES;
  localparam logic [1:0]  M_FLASH = 2'b00, M_SYS = 2'b01, M_EXT = 2'b10, M_SRAM1 = 2'b11;
  localparam int T_FLASH = 0, T_SYS = 1, T_SRAM1 = 2, T_SRAM2 = 3, T_EXT1 = 4, T_EXT2 = 5, T_CTL = 6;

  logic [CW-1:0] cnt;
  logic [1:0]    mode;
  logic          run;
  logic [6:0]    hit;
  logic [31:0]   base;

  wire capture = !run && !standby_exit && (cnt == CW'(CAPTURE_EDGE - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      run  <= 1'b0;
      mode <= M_FLASH;
    end else if (standby_exit) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (capture) begin
      run  <= 1'b1;
      mode <= {boot_b & boot_a, boot_a};
    end else if (!run) begin
      cnt <= cnt + 1'b1;
    end else if (remap_we) begin
      mode <= remap_wdata;
    end
  end

  always_comb begin
    hit  = '0;
    base = '0;
    if (addr < ALIAS_SPAN) begin
      case (mode)
        M_FLASH: hit[T_FLASH] = (addr < FLASH_BYTES);
        M_SYS:   hit[T_SYS]   = (addr < SYS_BYTES);
        M_SRAM1: hit[T_SRAM1] = (addr < SRAM1_BYTES);
        default: hit[T_EXT1]  = 1'b1;
      endcase
    end else if (addr < 2 * ALIAS_SPAN) begin
      hit[T_EXT2] = (mode == M_EXT);
      base = ALIAS_SPAN;
    end else if (addr - FLASH_BASE < FLASH_BYTES) begin
      hit[T_FLASH] = 1'b1;
      base = FLASH_BASE;
    end else if (addr - SYS_BASE < SYS_BYTES) begin
      hit[T_SYS] = 1'b1;
      base = SYS_BASE;
    end else if (addr - SRAM1_BASE < SRAM1_BYTES) begin
      hit[T_SRAM1] = 1'b1;
      base = SRAM1_BASE;
    end else if (addr - SRAM2_BASE < SRAM2_BYTES) begin
      hit[T_SRAM2] = 1'b1;
      base = SRAM2_BASE;
    end else if (addr - CTL_BASE < CTL_BYTES) begin
      hit[T_CTL] = (mode != M_EXT);
      base = CTL_BASE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_sel    <= '0;
      tgt_offset <= '0;
      bus_err    <= 1'b0;
    end else begin
      tgt_sel    <= addr_valid ? hit : '0;
      tgt_offset <= (addr_valid && |hit) ? addr - base : '0;
      bus_err    <= addr_valid && !(|hit);
    end
  end

  assign cpu_run     = run;
  assign pin_release = run;

  AST_STANDBY_HALTS: assert property (@(posedge clk) disable iff (!rst_n) standby_exit |=> !cpu_run); // R2
  AST_MODE_FROM_PINS: assert property (@(posedge clk) disable iff (!rst_n) $rose(cpu_run) |-> mode == {$past(boot_b) & $past(boot_a), $past(boot_a)}); // R3
  AST_WRITE_GATED: assert property (@(posedge clk) disable iff (!rst_n) (!cpu_run && !capture) |=> $stable(mode)); // R4
  AST_CTL_REFUSED: assert property (@(posedge clk) disable iff (!rst_n) (mode == M_EXT) |=> !tgt_sel[T_CTL]); // R9
  AST_SEL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(tgt_sel) && !(bus_err && |tgt_sel)); // R10
  AST_ERR_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n) bus_err |-> $past(addr_valid)); // R11
endmodule

// File: tb/boot_remap_decoder_tb.sv
module boot_remap_decoder_tb;
  logic        clk = 0, rst_n = 0, standby_exit = 0, boot_a = 0, boot_b = 0;
  logic        remap_we = 0, addr_valid = 0;
  logic [1:0]  remap_wdata = 0;
  logic [31:0] addr = 0;
  logic [6:0]  tgt_sel;
  logic [31:0] tgt_offset;
  logic        bus_err, pin_release, cpu_run;
  int checks = 0, errors = 0;
  bit done = 0;

  boot_remap_decoder u_dut (.clk, .rst_n, .standby_exit, .boot_a, .boot_b, .remap_we,
    .remap_wdata, .addr_valid, .addr, .tgt_sel, .tgt_offset, .bus_err, .pin_release, .cpu_run);

  always #4 clk = ~clk;

  int        m_cnt;
  bit        m_run;
  bit [1:0]  m_mode;
  bit [6:0]  m_sel;
  bit [31:0] m_off;
  bit        m_err;
  string     m_req;

  function automatic void decode(input bit v, input bit [31:0] a, input bit [1:0] md,
      output bit [6:0] s, output bit [31:0] o, output bit e, output string r);
    s = 0; o = 0; e = 0; r = "R10";
    if (!v) return;
    r = "R11";
    if (a < 32'h0400_0000) begin
      r = "R5 R6";
      if (md == 2'b10) begin s[4] = 1; o = a; end
      else if (md == 2'b00 && a < 32'h10_0000) begin s[0] = 1; o = a; end
      else if (md == 2'b01 && a < 32'h7800) begin s[1] = 1; o = a; end
      else if (md == 2'b11 && a < 32'h1_C000) begin s[2] = 1; o = a; end
    end else if (a < 32'h0800_0000) begin
      r = "R7";
      if (md == 2'b10) begin s[5] = 1; o = a - 32'h0400_0000; end
    end else if (a >= 32'h0800_0000 && a <= 32'h080F_FFFF) begin r = "R8"; s[0] = 1; o = a - 32'h0800_0000; end
    else if (a >= 32'h1FFF_0000 && a <= 32'h1FFF_77FF) begin r = "R8"; s[1] = 1; o = a - 32'h1FFF_0000; end
    else if (a >= 32'h2000_0000 && a <= 32'h2001_BFFF) begin r = "R8"; s[2] = 1; o = a - 32'h2000_0000; end
    else if (a >= 32'h2001_C000 && a <= 32'h2001_FFFF) begin r = "R8"; s[3] = 1; o = a - 32'h2001_C000; end
    else if (a >= 32'hA000_0000 && a <= 32'hA000_0FFF) begin
      r = "R9";
      if (md != 2'b10) begin s[6] = 1; o = a - 32'hA000_0000; end
    end
    e = (s == 0);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_run = 0; m_mode = 0; m_sel = 0; m_off = 0; m_err = 0; m_req = "R10";
    end else begin
      decode(addr_valid, addr, m_mode, m_sel, m_off, m_err, m_req);
      if (standby_exit) begin m_cnt = 0; m_run = 0; end
      else if (!m_run) begin
        if (m_cnt == 3) begin m_run = 1; m_mode = boot_a ? (boot_b ? 2'b11 : 2'b01) : 2'b00; end
        else m_cnt++;
      end else if (remap_we) m_mode = remap_wdata;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk("R1 R2 cpu_run", {31'b0, cpu_run}, {31'b0, m_run});
      chk("R1 R2 pin_release", {31'b0, pin_release}, {31'b0, m_run});
      chk({m_req, " sel"}, {25'b0, tgt_sel}, {25'b0, m_sel});
      chk({m_req, " offset"}, tgt_offset, m_off);
      chk({m_req, " bus_err"}, {31'b0, bus_err}, {31'b0, m_err});
    end
  end

  logic [31:0] alist [22] = '{32'h0, 32'h4, 32'h77FC, 32'h7800, 32'h1BFFC, 32'h1C000,
    32'hFFFFC, 32'h10_0000, 32'h03FF_FFFC, 32'h0400_0000, 32'h07FF_FFF0, 32'h0800_0010,
    32'h080F_FFFF, 32'h0810_0000, 32'h1FFF_0004, 32'h1FFF_7800, 32'h2000_0100,
    32'h2001_BFFF, 32'h2001_C000, 32'h2001_FFFF, 32'hA000_0010, 32'hA000_1000};

  task automatic sweep();
    foreach (alist[i]) begin
      @(negedge clk); addr_valid = 1; addr = alist[i];
      if (i % 5 == 4) begin @(negedge clk); addr_valid = 0; end
    end
    @(negedge clk); addr_valid = 0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] md);
    @(negedge clk); remap_we = 1; remap_wdata = md;
    @(negedge clk); remap_we = 0;
  endtask

  task automatic wake(input logic a, input logic b);
    @(negedge clk); standby_exit = 1; boot_a = a; boot_b = b;
    @(negedge clk); standby_exit = 0;
    wr(2'b10);                              // R4: ignored, still capturing
    repeat (4) @(negedge clk);
  endtask

  initial begin
    boot_a = 1; boot_b = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset run", {31'b0, cpu_run}, 32'd0);
    chk("R10 reset sel", {25'b0, tgt_sel}, 32'd0);
    @(negedge clk); rst_n = 1;
    repeat (3) @(posedge clk);
    #2 chk("R1 before 4th edge", {31'b0, cpu_run}, 32'd0);
    @(posedge clk);
    #2 chk("R1 at 4th edge", {31'b0, pin_release}, 32'd1);
    sweep();                                // R3 system memory from pins
    wr(2'b00); sweep();                     // R4 R5 R6 R8 R11
    wr(2'b11); sweep();
    wr(2'b10); sweep();                     // R7 R9
    wake(1, 1); sweep();                    // R2 R3 SRAM1
    wake(0, 1); sweep();                    // R3 flash
    wr(2'b10);
    @(negedge clk); addr_valid = 1; addr = 32'h0000_0010; standby_exit = 1;
    @(negedge clk); addr_valid = 0; standby_exit = 0;
    repeat (6) @(negedge clk);
    sweep();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule